// File: doc/BRIEF.md
# 8-bit ALU with Condition Codes

This block is the arithmetic and logic datapath of a small accumulator-based processor. It combines two 8-bit operands according to a 3-bit operation code and returns the 8-bit result at once. It also returns the set of condition flags that the operation would produce. A separate register holds the five condition flags and takes the new values on a clock edge only when the flag-write enable is high.

The supported operations are add, subtract, compare, increment, decrement, rotate right and rotate left through the carry, and a pass-through for loads. A writeback indication tells the surrounding datapath whether the result should be stored. Compare is the only operation that leaves it low. A branch-test input selects one of six flag conditions, and the block reports whether that condition holds on the registered flags.

Top module: `cc_alu`

## Requirements
- R1: Add (op 0) returns a+b modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, V is set on two's-complement overflow, N is result bit 7, and Z is set when the result is zero. $3D+$E2 gives $1F with H=0 N=0 Z=0 V=0 C=1, and $BD+$A3 gives $60 with H=1 N=0 Z=0 V=1 C=1.
- R2: Subtract (op 1) returns a-b modulo 256. C is set when a<b unsigned, V is set on signed overflow, N and Z follow the result, and H keeps its registered value.
- R3: Compare (op 2) produces the same result and flags as subtract but drives wr_o low. Every other operation drives wr_o high.
- R4: Increment (op 3) returns a+1 and decrement (op 4) returns a-1, both modulo 256. V is set only for $7F→$80 on increment and only for $80→$7F on decrement. N and Z follow the result, and C and H are unchanged.
- R5: Rotate right (op 5) returns {C,a[7:1]} with new C=a[0]. Rotate left (op 6) returns {a[6:0],C} with new C=a[7]. In both cases V = N xor new C and H is unchanged.
- R6: Pass (op 7) returns b. N and Z follow b, V is cleared, and C and H are unchanged.
- R7: The flag register takes flags_next_o on a rising clock edge only when flag_we_i is high. Otherwise it holds its value.
- R8: An active-low asynchronous reset clears all five flags.
- R9: br_take_o evaluates the registered flags according to br_sel_i: 0 gives Z, 1 gives !Z, 2 gives N, 3 gives !N, 4 gives C, 5 gives !C. Codes 6 and 7 give 0.
- R10: Flag vectors are laid out as {H,N,Z,V,C}, with H in bit 4 and C in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand (memory or other accumulator) |
| op_i | input | 3 | Operation code |
| flag_we_i | input | 1 | Flag register write enable |
| br_sel_i | input | 3 | Branch condition select |
| result_o | output | 8 | Operation result |
| wr_o | output | 1 | Result should be written back |
| flags_next_o | output | 5 | Flags this operation produces, {H,N,Z,V,C} |
| flags_o | output | 5 | Registered flags, {H,N,Z,V,C} |
| br_take_o | output | 1 | Selected branch condition holds |

## Verification
The assertions check on every cycle the properties that are local in time. These are loading and holding of the flag register, agreement of Z and N with the result, the missing writeback on compare, preservation of C and H on increment and decrement, the carry taken by rotate right, V on pass, and the equal-branch test. Arithmetic correctness needs a reference model running through the bench's scenarios. That covers carry, half-carry and overflow values, borrow polarity, wrap-around at $7F/$80/$FF/$00, carry rotating in, and every branch code. Reset clearing flags that had been set is likewise only shown by a scenario.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  localparam int FLAG_W = 5;
  localparam int FL_C = 0;
  localparam int FL_V = 1;
  localparam int FL_Z = 2;
  localparam int FL_N = 3;
  localparam int FL_H = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4,
    OP_ROR  = 3'd5,
    OP_ROL  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_EQ   = 3'd0,
    BR_NE   = 3'd1,
    BR_MI   = 3'd2,
    BR_PL   = 3'd3,
    BR_CS   = 3'd4,
    BR_CC   = 3'd5,
    BR_NV6  = 3'd6,
    BR_NV7  = 3'd7
  } br_cond_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_half_o,
  output logic         c_out_o,
  output logic         ovf_o
);
  localparam int HW = W / 2;

  logic [HW:0]  lo_sum;
  logic [W-1:0] low_msb_sum;
  logic [W:0]   full_sum;

  always_comb begin
    lo_sum      = {1'b0, x_i[HW-1:0]} + {1'b0, y_i[HW-1:0]} + {{HW{1'b0}}, cin_i};
    low_msb_sum = {1'b0, x_i[W-2:0]} + {1'b0, y_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
    full_sum    = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  end

  assign sum_o    = full_sum[W-1:0];
  assign c_out_o  = full_sum[W];
  assign c_half_o = lo_sum[HW];
  // overflow: carry into msb differs from carry out of msb
  assign ovf_o    = full_sum[W] ^ low_msb_sum[W-1];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import cc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  ccr_t         ccr_i,
  output logic [W-1:0] result_o,
  output ccr_t         ccr_o,
  output logic         wr_o
);
  logic [W-1:0] add_y;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_ch, add_co, add_ov;
  logic [W-1:0] res;
  ccr_t         nf;

  // operand steering for the shared adder
  always_comb begin
    add_y   = b_i;
    add_cin = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin add_y = ~b_i;       add_cin = 1'b1; end
      OP_INC:         begin add_y = '0;         add_cin = 1'b1; end
      OP_DEC:         begin add_y = '1;         add_cin = 1'b0; end
      default:        begin add_y = b_i;        add_cin = 1'b0; end
    endcase
  end

  alu_addsub #(.W(W)) u_add (
    .x_i      (a_i),
    .y_i      (add_y),
    .cin_i    (add_cin),
    .sum_o    (add_sum),
    .c_half_o (add_ch),
    .c_out_o  (add_co),
    .ovf_o    (add_ov)
  );

  always_comb begin
    nf  = ccr_i;
    res = add_sum;
    unique case (op_i)
      OP_ADD: begin
        res  = add_sum;
        nf.c = add_co;
        nf.h = add_ch;
        nf.v = add_ov;
      end
      OP_SUB, OP_CMP: begin
        res  = add_sum;
        nf.c = ~add_co;
        nf.v = add_ov;
      end
      OP_INC, OP_DEC: begin
        res  = add_sum;
        nf.v = add_ov;
      end
      OP_ROR: begin
        res  = {ccr_i.c, a_i[W-1:1]};
        nf.c = a_i[0];
        nf.v = res[W-1] ^ a_i[0];
      end
      OP_ROL: begin
        res  = {a_i[W-2:0], ccr_i.c};
        nf.c = a_i[W-1];
        nf.v = res[W-1] ^ a_i[W-1];
      end
      OP_PASS: begin
        res  = b_i;
        nf.v = 1'b0;
      end
      default: res = add_sum;
    endcase
    nf.n = res[W-1];
    nf.z = ~|res;
  end

  assign result_o = res;
  assign ccr_o    = nf;
  assign wr_o     = (op_i != OP_CMP);
endmodule

// File: rtl/alu_ccr_reg.sv
module alu_ccr_reg
  import cc_alu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  ccr_t d_i,
  output ccr_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_branch.sv
module alu_branch
  import cc_alu_pkg::*;
(
  input  ccr_t     ccr_i,
  input  br_cond_e sel_i,
  output logic     take_o
);
  always_comb begin
    unique case (sel_i)
      BR_EQ:   take_o =  ccr_i.z;
      BR_NE:   take_o = ~ccr_i.z;
      BR_MI:   take_o =  ccr_i.n;
      BR_PL:   take_o = ~ccr_i.n;
      BR_CS:   take_o =  ccr_i.c;
      BR_CC:   take_o = ~ccr_i.c;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  input  logic              flag_we_i,
  input  logic [2:0]        br_sel_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_o,
  output logic [FLAG_W-1:0] flags_next_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              br_take_o
);
  ccr_t ccr_q, ccr_d;

  alu_core #(.W(DATA_W)) u_core (
    .op_i     (alu_op_e'(op_i)),
    .a_i      (a_i),
    .b_i      (b_i),
    .ccr_i    (ccr_q),
    .result_o (result_o),
    .ccr_o    (ccr_d),
    .wr_o     (wr_o)
  );

  alu_ccr_reg u_ccr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we_i),
    .d_i    (ccr_d),
    .q_o    (ccr_q)
  );

  alu_branch u_br (
    .ccr_i  (ccr_q),
    .sel_i  (br_cond_e'(br_sel_i)),
    .take_o (br_take_o)
  );

  assign flags_next_o = ccr_d;
  assign flags_o      = ccr_q;
endmodule

// File: rtl/cc_alu_checks.sv
module cc_alu_checks
  import cc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [2:0]        op_i,
  input logic              flag_we_i,
  input logic [2:0]        br_sel_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_o,
  input logic [FLAG_W-1:0] flags_next_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              br_take_o
);
  p_we_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o == $past(flags_next_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  p_zn_track_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_next_o[FL_Z] == (result_o == '0)) && (flags_next_o[FL_N] == result_o[DATA_W-1]));

  p_cmp_nowb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |-> !wr_o);

  p_incdec_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC || op_i == OP_DEC) |->
      (flags_next_o[FL_C] == flags_o[FL_C]) && (flags_next_o[FL_H] == flags_o[FL_H]));

  p_ror_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ROR) |-> flags_next_o[FL_C] == a_i[0]);

  p_pass_v_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PASS) |-> (result_o == b_i) && !flags_next_o[FL_V]);

  p_branch_eq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_sel_i == BR_EQ) |-> br_take_o == flags_o[FL_Z]);
endmodule

bind cc_alu cc_alu_checks #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .a_i          (a_i),
  .b_i          (b_i),
  .op_i         (op_i),
  .flag_we_i    (flag_we_i),
  .br_sel_i     (br_sel_i),
  .result_o     (result_o),
  .wr_o         (wr_o),
  .flags_next_o (flags_next_o),
  .flags_o      (flags_o),
  .br_take_o    (br_take_o)
);

// File: tb/tb_cc_alu.sv
`timescale 1ns/1ps
module tb_cc_alu;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [2:0] op_i = '0, br_sel_i = '0;
  logic       flag_we_i = 1'b0;
  logic [7:0] result_o;
  logic       wr_o, br_take_o;
  logic [4:0] flags_next_o, flags_o;

  int n_chk = 0, n_err = 0;
  int mflags = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cc_alu dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .flag_we_i(flag_we_i), .br_sel_i(br_sel_i), .result_o(result_o), .wr_o(wr_o),
    .flags_next_o(flags_next_o), .flags_o(flags_o), .br_take_o(br_take_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  // behavioural reference; flag vector {H,N,Z,V,C} per R10
  function automatic void ref_step(input int op, input int a, input int b, input int f,
                                   output int r, output int fn, output int wr);
    int h, n, z, v, c, sa, sb;
    h = (f >> 4) & 1; v = (f >> 1) & 1; c = f & 1;
    sa = (a >= 128) ? a - 256 : a;
    sb = (b >= 128) ? b - 256 : b;
    r = 0;
    case (op)
      0: begin
        r = (a + b) % 256; c = (a + b > 255) ? 1 : 0;
        h = ((a % 16) + (b % 16) > 15) ? 1 : 0;
        v = (sa + sb > 127 || sa + sb < -128) ? 1 : 0;
      end
      1, 2: begin
        r = (a - b + 256) % 256; c = (a < b) ? 1 : 0;
        v = (sa - sb > 127 || sa - sb < -128) ? 1 : 0;
      end
      3: begin r = (a + 1) % 256;   v = (a == 127) ? 1 : 0; end
      4: begin r = (a + 255) % 256; v = (a == 128) ? 1 : 0; end
      5: begin r = a / 2 + c * 128; c = a % 2; end
      6: begin r = (a * 2) % 256 + c; c = a / 128; end
      default: begin r = b; v = 0; end
    endcase
    n = (r >= 128) ? 1 : 0;
    z = (r == 0) ? 1 : 0;
    if (op == 5 || op == 6) v = n ^ c;
    wr = (op == 2) ? 0 : 1;
    fn = h * 16 + n * 8 + z * 4 + v * 2 + c;
  endfunction

  function automatic int ref_br(input int sel, input int f);
    int n, z, c;
    n = (f >> 3) & 1; z = (f >> 2) & 1; c = f & 1;
    case (sel)
      0: return z;
      1: return 1 - z;
      2: return n;
      3: return 1 - n;
      4: return c;
      5: return 1 - c;
      default: return 0;
    endcase
  endfunction

  task automatic apply(input int op, input int a, input int b, input bit we, input int br);
    int r, fn, wr;
    @(negedge clk_i);
    op_i = op[2:0]; a_i = a[7:0]; b_i = b[7:0]; flag_we_i = we; br_sel_i = br[2:0];
    #1;
    ref_step(op, a, b, mflags, r, fn, wr);
    check(req_of(op), "result", int'(result_o), r);
    check(req_of(op), "flags_next", int'(flags_next_o), fn);
    check("R3", "wr", int'(wr_o), wr);
    check("R9", "branch", int'(br_take_o), ref_br(br, mflags));
    @(posedge clk_i);
    #1;
    if (we) mflags = fn;
    check("R7", "flags", int'(flags_o), mflags);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R8", "flags in reset", int'(flags_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 worked examples
    apply(0, 'h3D, 'hE2, 1, 0);
    check("R1", "3D+E2 flags", int'(flags_o), 'h01);
    apply(0, 'hBD, 'hA3, 1, 4);
    check("R1", "BD+A3 flags", int'(flags_o), 'h13);
    apply(0, 'h80, 'h80, 1, 0);
    // R2 subtract; H must stay from previous add
    apply(1, 'h10, 'h20, 1, 4);
    apply(1, 'h80, 'h01, 1, 0);
    apply(1, 'h55, 'h55, 1, 0);
    // R3 compare
    apply(2, 'h05, 'h07, 1, 1);
    apply(2, 'h7F, 'hFF, 1, 2);
    // R4 inc/dec wrap and overflow
    apply(3, 'h7F, 0, 1, 3);
    apply(3, 'hFF, 0, 1, 0);
    apply(4, 'h80, 0, 1, 2);
    apply(4, 'h00, 0, 1, 3);
    // R5 rotates through carry
    apply(0, 'hFF, 'h01, 1, 4);
    apply(5, 'h02, 0, 1, 5);
    apply(6, 'h81, 0, 1, 4);
    apply(6, 'h40, 0, 1, 5);
    apply(5, 'h01, 0, 1, 4);
    // R6 pass
    apply(7, 'hAA, 'h00, 1, 0);
    apply(7, 0, 'h80, 1, 2);
    // R7 hold with enable low
    apply(0, 'hBD, 'hA3, 1, 0);
    apply(7, 0, 'h00, 0, 0);
    apply(1, 'h00, 'h01, 0, 4);
    // R9 all branch codes on current flags
    for (int s = 0; s < 8; s++) apply(7, 0, 'h00, 0, s);
    apply(2, 'h00, 'h01, 1, 0);
    for (int s = 0; s < 8; s++) apply(7, 0, 'h00, 0, s);
    // R8 asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R8", "flags after async reset", int'(flags_o), 0);
    mflags = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    // random sweep
    for (int i = 0; i < 600; i++)
      apply(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), bit'($urandom_range(0, 3) != 0),
            int'($urandom_range(0, 7)));
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule